// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block watches the command pins of a four-bank SDRAM device. On every rising clock edge it turns the chip select, row strobe, column strobe and write enable levels into a command. It keeps an open or closed state for each bank, together with a single data-burst tracker and a precharge-recovery counter for each bank. When a command breaks an ordering rule, the block raises a one-cycle violation flag. The flag carries an error code and the bank involved. The monitor drives nothing onto the memory bus.

For each burst beat the monitor also gives two expected data-path controls after the byte mask is applied. One is the write-data keep strobe, for which the mask acts in the same cycle. The other is the read output enable, for which the mask acts two cycles later. Burst length and precharge recovery time are configuration inputs. The column address has no effect on sequencing, so only the auto-precharge address line is sampled. Power-down and clock-suspend cycles decode as no-operation. A cycle whose previous clock-enable sample was low decodes no command.

Top module: `sdram_seq_monitor`

## Requirements
- R1: A command is decoded only when `pin_cs_n` is low and the previous `pin_cke` sample was high. Deselected cycles and no-operation (RAS#,CAS#,WE# = 111) never raise a violation.
- R2: `pin_ba` selects the bank for activate, read, write and single-bank precharge, with value 0..3 naming banks 0..3. A single-bank precharge (code 010 with `pin_ap` low) closes only the named bank. Precharging a closed bank gives error 9.
- R3: A precharge with `pin_ap` high closes every bank whatever `pin_ba` holds. It also ends any burst in progress and never flags.
- R4: Activate (011) opens a bank. Activate to a bank that is already open gives error 7.
- R5: Read (101) or write (100) to a closed bank gives error 5.
- R6: A mode register set (000) issued while any bank is open gives error 1, and the lowest open bank is reported.
- R7: After an accepted mode register set, any decoded command other than no-operation on either of the next two edges gives error 2.
- R8: Auto refresh (001 with CKE high on both samples) while any bank is open gives error 3. Self-refresh entry (001 with CKE high on the previous sample and low on the current one) while any bank is open gives error 4. Both report the lowest open bank.
- R9: A read or write with `pin_ap` high starts an auto-precharge burst. While any of its beats remain, a new read or write gives error 6. After it ends, reads and writes to other open banks are accepted and its bank is closed.
- R10: When an auto-precharge burst ends on edge k, an activate to that bank is accepted from edge k+`cfg_trp` onward. Before that it gives error 8.
- R11: `cfg_bl_sel` = 0,1,2,3 selects burst length 1,2,4,8. The read or write edge is beat 0. A burst stop (110) ends the burst at once with no beat on that edge, at any burst length. If the burst had auto-precharge, its bank closes and recovery starts.
- R12: `wr_keep` is high after edge k when a write beat falls on edge k and `pin_dqm` is low on edge k (write mask latency 0).
- R13: `rd_oe` is high after edge k+2 when a read beat fell on edge k and `pin_dqm` was low on edge k (read mask latency 2).
- R14: A violation is reported as a registered one-cycle `viol_valid` pulse visible after the offending edge, with `viol_code` and `viol_bank`. A violating command changes no bank state. Reset clears all banks, the burst and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bl_sel | input | 2 | Burst length select (1,2,4,8) |
| cfg_trp | input | TRP_W | Precharge recovery time in clocks |
| pin_cke | input | 1 | Clock enable pin |
| pin_cs_n | input | 1 | Chip select, active low |
| pin_ras_n | input | 1 | Row strobe, active low |
| pin_cas_n | input | 1 | Column strobe, active low |
| pin_we_n | input | 1 | Write enable, active low |
| pin_ba | input | 2 | Bank address |
| pin_ap | input | 1 | Auto-precharge / all-bank address line |
| pin_dqm | input | 1 | Data byte mask |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Error code, 0 when no violation |
| viol_bank | output | 2 | Bank of the violation, 0 when none |
| rd_oe | output | 1 | Expected read data output enable |
| wr_keep | output | 1 | Expected write data accepted |

## Verification
A violation and `wr_keep` come from the inputs sampled on edge k and appear after that same edge. `rd_oe` for a beat on edge k appears after edge k+2. The bench drives the pins on the falling edge. A behavioural model in the bench, built from queues and integer arrays, updates on each rising edge. The bench compares all five outputs with that model one nanosecond after every rising edge, so each result is checked in the cycle it is due. The model delays the read enable through a two-entry queue, which pins its lag to exactly two edges beyond the write strobe.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
    localparam int NBANK    = 4;
    localparam int BA_W     = $clog2(NBANK);
    localparam int BLSEL_W  = 2;
    localparam int REM_W    = 3;   // holds up to (longest burst - 1)
    localparam int LOCK_CYC = 2;   // edges locked after mode register set
    localparam int LOCK_W   = $clog2(LOCK_CYC + 1);

    typedef enum logic [3:0] {
        CMD_NONE, CMD_NOP, CMD_MRS, CMD_REF, CMD_SREF,
        CMD_ACT,  CMD_RD,  CMD_WR,  CMD_PRE, CMD_BST
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_MRS_BUSY  = 4'd1,
        ERR_MRS_LOCK  = 4'd2,
        ERR_REF_BUSY  = 4'd3,
        ERR_SREF_BUSY = 4'd4,
        ERR_RW_IDLE   = 4'd5,
        ERR_RW_AP     = 4'd6,
        ERR_ACT_OPEN  = 4'd7,
        ERR_ACT_TRP   = 4'd8,
        ERR_PRE_IDLE  = 4'd9
    } err_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (cke_prev && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
    parameter int TRP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic             trp_load,
    input  logic [TRP_W-1:0] trp_val,
    output logic             is_open,
    output logic             trp_block
);
    typedef struct packed {
        logic             open;
        logic [TRP_W-1:0] cnt;
    } slot_t;

    slot_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
        if (open_set)      s_d.open = 1'b1;
        if (close)         s_d.open = 1'b0;
        if (trp_load)      s_d.cnt  = trp_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign is_open   = s_q.open;
    assign trp_block = s_q.cnt > TRP_W'(1);
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track
    import sdram_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_rd,
    input  logic               start_ap,
    input  logic [BA_W-1:0]    start_bank,
    input  logic [BLSEL_W-1:0] bl_sel,
    input  logic               stop,
    input  logic               kill,
    input  logic               kill_all,
    input  logic [BA_W-1:0]    kill_bank,
    input  logic               dqm,
    output logic               ap_run,
    output logic               ap_end,
    output logic [BA_W-1:0]    ap_end_bank,
    output logic               rd_oe,
    output logic               wr_keep
);
    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic             rd;
        logic             ap;
        logic [BA_W-1:0]  bank;
        logic             rd_s1;
        logic             rd_s2;
        logic             rd_oe;
        logic             wr_keep;
    } burst_t;

    burst_t s_q, s_d;
    logic   beat, beat_rd, cut;
    logic [REM_W-1:0] rem_start;

    assign rem_start = REM_W'((32'd1 << bl_sel) - 32'd1);
    assign cut       = stop || (kill && (kill_all || kill_bank == s_q.bank));

    always_comb begin
        s_d         = s_q;
        beat        = 1'b0;
        beat_rd     = 1'b0;
        ap_end      = 1'b0;
        ap_end_bank = s_q.bank;
        if (start) begin
            beat        = 1'b1;
            beat_rd     = start_rd;
            s_d.rem     = rem_start;
            s_d.rd      = start_rd;
            s_d.ap      = start_ap;
            s_d.bank    = start_bank;
            ap_end      = start_ap && (rem_start == '0);
            ap_end_bank = start_bank;
        end else if (s_q.rem != '0) begin
            if (cut) begin
                ap_end  = stop && s_q.ap;
                s_d.rem = '0;
            end else begin
                beat    = 1'b1;
                beat_rd = s_q.rd;
                ap_end  = s_q.ap && (s_q.rem == REM_W'(1));
                s_d.rem = s_q.rem - 1'b1;
            end
        end
        s_d.rd_s1   = beat && beat_rd && !dqm;
        s_d.rd_s2   = s_q.rd_s1;
        s_d.rd_oe   = s_q.rd_s2;
        s_d.wr_keep = beat && !beat_rd && !dqm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ap_run  = (s_q.rem != '0) && s_q.ap;
    assign rd_oe   = s_q.rd_oe;
    assign wr_keep = s_q.wr_keep;
endmodule

// File: rtl/sdram_seq_monitor.sv
module sdram_seq_monitor
    import sdram_mon_pkg::*;
#(
    parameter int TRP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BLSEL_W-1:0] cfg_bl_sel,
    input  logic [TRP_W-1:0]   cfg_trp,
    input  logic               pin_cke,
    input  logic               pin_cs_n,
    input  logic               pin_ras_n,
    input  logic               pin_cas_n,
    input  logic               pin_we_n,
    input  logic [BA_W-1:0]    pin_ba,
    input  logic               pin_ap,
    input  logic               pin_dqm,
    output logic               viol_valid,
    output logic [3:0]         viol_code,
    output logic [BA_W-1:0]    viol_bank,
    output logic               rd_oe,
    output logic               wr_keep
);
    typedef struct packed {
        logic              cke_prev;
        logic [LOCK_W-1:0] lock;
        logic              vld;
        err_e              code;
        logic [BA_W-1:0]   bank;
    } top_t;

    top_t s_q, s_d;
    cmd_e cmd;
    err_e err;
    logic [BA_W-1:0]  err_bank, first_open, ap_end_bank;
    logic [NBANK-1:0] open_vec, trp_vec, set_v, close_v, load_v;
    logic act_ok, rw_ok, pre_ok, bst_ok, mrs_ok;
    logic ap_run, ap_end, lock_busy, any_open;

    sdram_cmd_decode u_dec (
        .cke_prev (s_q.cke_prev), .cke (pin_cke), .cs_n (pin_cs_n),
        .ras_n (pin_ras_n), .cas_n (pin_cas_n), .we_n (pin_we_n), .cmd (cmd)
    );

    assign lock_busy = s_q.lock != '0;
    assign any_open  = |open_vec;

    always_comb begin
        first_open = '0;
        for (int b = NBANK - 1; b >= 0; b--)
            if (open_vec[b]) first_open = BA_W'(b);
    end

    always_comb begin
        s_d          = s_q;
        s_d.cke_prev = pin_cke;
        s_d.lock     = lock_busy ? s_q.lock - 1'b1 : '0;
        err      = ERR_NONE;
        err_bank = pin_ba;
        act_ok = 1'b0; rw_ok = 1'b0; pre_ok = 1'b0; bst_ok = 1'b0; mrs_ok = 1'b0;
        if (cmd != CMD_NONE && cmd != CMD_NOP && lock_busy) begin
            err = ERR_MRS_LOCK;
        end else begin
            case (cmd)
                CMD_MRS: if (any_open) begin err = ERR_MRS_BUSY; err_bank = first_open; end
                         else mrs_ok = 1'b1;
                CMD_REF: if (any_open) begin err = ERR_REF_BUSY; err_bank = first_open; end
                CMD_SREF: if (any_open) begin err = ERR_SREF_BUSY; err_bank = first_open; end
                CMD_ACT: if (open_vec[pin_ba])     err = ERR_ACT_OPEN;
                         else if (trp_vec[pin_ba]) err = ERR_ACT_TRP;
                         else act_ok = 1'b1;
                CMD_RD, CMD_WR: if (ap_run)        err = ERR_RW_AP;
                         else if (!open_vec[pin_ba]) err = ERR_RW_IDLE;
                         else rw_ok = 1'b1;
                CMD_PRE: if (!pin_ap && !open_vec[pin_ba]) err = ERR_PRE_IDLE;
                         else pre_ok = 1'b1;
                CMD_BST: bst_ok = 1'b1;
                default: ;
            endcase
        end
        if (mrs_ok) s_d.lock = LOCK_W'(LOCK_CYC);
        s_d.vld  = err != ERR_NONE;
        s_d.code = err;
        s_d.bank = (err != ERR_NONE) ? err_bank : '0;
        for (int b = 0; b < NBANK; b++) begin
            set_v[b]   = act_ok && pin_ba == BA_W'(b);
            load_v[b]  = ap_end && ap_end_bank == BA_W'(b);
            close_v[b] = (pre_ok && (pin_ap || pin_ba == BA_W'(b))) || load_v[b];
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdram_bank_slot #(.TRP_W(TRP_W)) u_slot (
            .clk (clk), .rst_n (rst_n),
            .open_set (set_v[g]), .close (close_v[g]), .trp_load (load_v[g]),
            .trp_val (cfg_trp), .is_open (open_vec[g]), .trp_block (trp_vec[g])
        );
    end

    sdram_burst_track u_burst (
        .clk (clk), .rst_n (rst_n),
        .start (rw_ok), .start_rd (cmd == CMD_RD), .start_ap (pin_ap),
        .start_bank (pin_ba), .bl_sel (cfg_bl_sel),
        .stop (bst_ok), .kill (pre_ok), .kill_all (pin_ap), .kill_bank (pin_ba),
        .dqm (pin_dqm), .ap_run (ap_run), .ap_end (ap_end),
        .ap_end_bank (ap_end_bank), .rd_oe (rd_oe), .wr_keep (wr_keep)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.cke_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign viol_valid = s_q.vld;
    assign viol_code  = s_q.code;
    assign viol_bank  = s_q.bank;
endmodule

// File: rtl/sdram_mon_chk.sv
module sdram_mon_chk
    import sdram_mon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input cmd_e             cmd,
    input logic [NBANK-1:0] open_vec,
    input logic             ap_run,
    input logic             lock_busy,
    input logic [BA_W-1:0]  pin_ba,
    input logic             pin_dqm,
    input logic             viol_valid,
    input logic [3:0]       viol_code,
    input logic             rd_oe,
    input logic             wr_keep
);
    // R1
    idle_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> ($past(cmd) != CMD_NONE && $past(cmd) != CMD_NOP));

    // R14
    code_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid == (viol_code != 4'd0));

    // R4
    act_open_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && open_vec[pin_ba] && !lock_busy)
        |=> (viol_valid && viol_code == 4'd7));

    // R6
    mrs_busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && (|open_vec) && !lock_busy)
        |=> (viol_valid && viol_code == 4'd1));

    // R9
    ap_burst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && ap_run && !lock_busy)
        |=> (viol_valid && viol_code == 4'd6));

    // R12
    wr_mask_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_keep |-> !$past(pin_dqm));

    // R13
    rd_mask_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> !$past(pin_dqm, 3));
endmodule

bind sdram_seq_monitor sdram_mon_chk u_chk (
    .clk (clk), .rst_n (rst_n), .cmd (cmd), .open_vec (open_vec),
    .ap_run (ap_run), .lock_busy (lock_busy), .pin_ba (pin_ba),
    .pin_dqm (pin_dqm), .viol_valid (viol_valid), .viol_code (viol_code),
    .rd_oe (rd_oe), .wr_keep (wr_keep)
);

// File: tb/tb_sdram_seq_monitor.sv
`timescale 1ns/1ps
module tb_sdram_seq_monitor;
    localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_ACT = 3'b011,
        C_RD = 3'b101, C_WR = 3'b100, C_BST = 3'b110, C_PRE = 3'b010, C_NOP = 3'b111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_bl_sel = 2'd0;
    logic [3:0] cfg_trp = 4'd2;
    logic pin_cke = 1'b1, pin_cs_n = 1'b1, pin_ras_n = 1'b1, pin_cas_n = 1'b1, pin_we_n = 1'b1;
    logic [1:0] pin_ba = 2'd0;
    logic pin_ap = 1'b0, pin_dqm = 1'b0;
    logic viol_valid, rd_oe, wr_keep;
    logic [3:0] viol_code;
    logic [1:0] viol_bank;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string cur_req = "R14 reset state";

    always #2 clk = ~clk;

    sdram_seq_monitor #(.TRP_W(4)) dut (
        .clk, .rst_n, .cfg_bl_sel, .cfg_trp, .pin_cke, .pin_cs_n, .pin_ras_n,
        .pin_cas_n, .pin_we_n, .pin_ba, .pin_ap, .pin_dqm,
        .viol_valid, .viol_code, .viol_bank, .rd_oe, .wr_keep
    );

    // behavioural reference
    int mo[4], mt[4];
    int mrem, mbank, mlock;
    bit map, mrd, mckep;
    bit ev, ewr, erd;
    int ecode, ebank;
    bit rq[$];

    initial begin
        rq = '{0, 0};
        mckep = 1;
    end

    always @(posedge clk) begin : ref_model
        string c;
        int err, eb, first, blen, apbank;
        bit anyopen, act, rw, pre, bst, mrs, beat, isrd, apend, aprun;
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin mo[b] = 0; mt[b] = 0; end
            mrem = 0; mbank = 0; mlock = 0; map = 0; mrd = 0; mckep = 1;
            ev = 0; ecode = 0; ebank = 0; ewr = 0; erd = 0; rq = '{0, 0};
        end else begin
            c = "none";
            if (mckep && !pin_cs_n) begin
                case ({pin_ras_n, pin_cas_n, pin_we_n})
                    C_MRS: c = "mrs";
                    C_REF: c = pin_cke ? "ref" : "sref";
                    C_ACT: c = "act";
                    C_RD:  c = "rd";
                    C_WR:  c = "wr";
                    C_BST: c = "bst";
                    C_PRE: c = "pre";
                    default: c = "nop";
                endcase
            end
            err = 0; eb = pin_ba;
            act = 0; rw = 0; pre = 0; bst = 0; mrs = 0;
            anyopen = 0; first = 0;
            for (int b = 3; b >= 0; b--) if (mo[b] != 0) begin anyopen = 1; first = b; end
            aprun = (mrem > 0) && map;
            if (c != "none" && c != "nop" && mlock > 0) err = 2;
            else if (c == "mrs") begin if (anyopen) begin err = 1; eb = first; end else mrs = 1; end
            else if (c == "ref") begin if (anyopen) begin err = 3; eb = first; end end
            else if (c == "sref") begin if (anyopen) begin err = 4; eb = first; end end
            else if (c == "act") begin
                if (mo[pin_ba] != 0) err = 7; else if (mt[pin_ba] > 1) err = 8; else act = 1;
            end else if (c == "rd" || c == "wr") begin
                if (aprun) err = 6; else if (mo[pin_ba] == 0) err = 5; else rw = 1;
            end else if (c == "pre") begin
                if (!pin_ap && mo[pin_ba] == 0) err = 9; else pre = 1;
            end else if (c == "bst") bst = 1;

            beat = 0; isrd = 0; apend = 0; apbank = 0;
            if (rw) begin
                beat = 1; isrd = (c == "rd"); blen = 1 << cfg_bl_sel;
                mrem = blen - 1; map = pin_ap; mrd = isrd; mbank = pin_ba;
                if (blen == 1 && pin_ap) begin apend = 1; apbank = pin_ba; end
            end else if (mrem > 0) begin
                if (bst || (pre && (pin_ap || pin_ba == mbank))) begin
                    if (bst && map) begin apend = 1; apbank = mbank; end
                    mrem = 0;
                end else begin
                    beat = 1; isrd = mrd;
                    if (mrem == 1 && map) begin apend = 1; apbank = mbank; end
                    mrem = mrem - 1;
                end
            end
            for (int b = 0; b < 4; b++) begin
                if (mt[b] > 0) mt[b] = mt[b] - 1;
                if (act && pin_ba == b) mo[b] = 1;
                if (pre && (pin_ap || pin_ba == b)) mo[b] = 0;
                if (apend && apbank == b) begin mo[b] = 0; mt[b] = cfg_trp; end
            end
            mlock = mrs ? 2 : (mlock > 0 ? mlock - 1 : 0);
            mckep = pin_cke;
            ev = (err != 0); ecode = err; ebank = ev ? eb : 0;
            ewr = beat && !isrd && !pin_dqm;
            rq.push_back(beat && isrd && !pin_dqm);
            erd = rq.pop_front();
        end
    end

    always @(posedge clk) begin
        #1;
        if (!done) begin
            n_cmp++;
            if (viol_valid !== ev || viol_code !== 4'(ecode) || viol_bank !== 2'(ebank)
                || wr_keep !== ewr || rd_oe !== erd) begin
                n_bad++;
                $display("FAIL %s t=%0t got v=%b code=%0d bank=%0d wr=%b rd=%b exp v=%b code=%0d bank=%0d wr=%b rd=%b",
                    cur_req, $time, viol_valid, viol_code, viol_bank, wr_keep, rd_oe,
                    ev, ecode, ebank, ewr, erd);
            end
        end
    end

    task automatic step(input logic cs_n, input logic [2:0] rcw, input logic [1:0] ba,
                        input logic ap, input logic dqm, input logic cke);
        @(negedge clk);
        pin_cs_n = cs_n; {pin_ras_n, pin_cas_n, pin_we_n} = rcw;
        pin_ba = ba; pin_ap = ap; pin_dqm = dqm; pin_cke = cke;
    endtask

    task automatic cmd(input logic [2:0] rcw, input logic [1:0] ba, input logic ap);
        step(1'b0, rcw, ba, ap, 1'b0, 1'b1);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(1'b1, C_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired in %s", cur_req);
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1 deselect and nop";
        step(1'b1, C_MRS, 2'd1, 1'b1, 1'b0, 1'b1);
        step(1'b1, C_ACT, 2'd2, 1'b0, 1'b0, 1'b1);
        cmd(C_NOP, 2'd3, 1'b1);

        cur_req = "R7 mode register lockout";
        cmd(C_MRS, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);

        cur_req = "R4 activate open bank";
        cmd(C_ACT, 2'd0, 1'b0);

        cur_req = "R6 mode register with open bank";
        cmd(C_MRS, 2'd1, 1'b0);

        cur_req = "R8 refresh with open bank";
        cmd(C_REF, 2'd0, 1'b0);
        step(1'b0, C_REF, 2'd0, 1'b0, 1'b0, 1'b0);
        step(1'b0, C_ACT, 2'd0, 1'b0, 1'b0, 1'b1);
        nops(1);

        cur_req = "R5 access to closed bank";
        cmd(C_RD, 2'd2, 1'b0);
        cur_req = "R2 precharge closed bank";
        cmd(C_PRE, 2'd3, 1'b0);

        cur_req = "R12 write mask latency";
        cfg_bl_sel = 2'd2;
        step(1'b0, C_WR, 2'd0, 1'b0, 1'b0, 1'b1);
        step(1'b1, C_NOP, 2'd0, 1'b0, 1'b1, 1'b1);
        step(1'b1, C_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
        step(1'b1, C_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
        nops(2);

        cur_req = "R13 read mask latency";
        step(1'b0, C_RD, 2'd0, 1'b0, 1'b1, 1'b1);
        step(1'b1, C_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
        step(1'b1, C_NOP, 2'd0, 1'b0, 1'b1, 1'b1);
        step(1'b1, C_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
        nops(4);

        cur_req = "R11 burst stop";
        cfg_bl_sel = 2'd3;
        cmd(C_RD, 2'd0, 1'b0);
        nops(1);
        cmd(C_BST, 2'd0, 1'b0);
        nops(4);
        cmd(C_BST, 2'd0, 1'b0);

        cur_req = "R9 auto-precharge burst";
        cmd(C_ACT, 2'd1, 1'b0);
        cfg_bl_sel = 2'd2; cfg_trp = 4'd3;
        cmd(C_RD, 2'd0, 1'b1);
        cmd(C_RD, 2'd1, 1'b0);
        cmd(C_WR, 2'd1, 1'b0);
        nops(1);
        cur_req = "R10 recovery window";
        cmd(C_ACT, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);
        cur_req = "R9 other bank after burst";
        cmd(C_RD, 2'd1, 1'b0);
        nops(5);

        cur_req = "R11 stop of auto-precharge burst";
        cfg_bl_sel = 2'd3; cfg_trp = 4'd2;
        cmd(C_WR, 2'd0, 1'b1);
        nops(1);
        cmd(C_BST, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);

        cur_req = "R3 precharge all";
        cmd(C_PRE, 2'd2, 1'b1);
        cmd(C_RD, 2'd1, 1'b0);
        cmd(C_RD, 2'd0, 1'b0);

        cur_req = "R2 bank select";
        cmd(C_ACT, 2'd3, 1'b0);
        cmd(C_RD, 2'd3, 1'b0);
        cmd(C_RD, 2'd2, 1'b0);
        cmd(C_PRE, 2'd3, 1'b0);
        cmd(C_PRE, 2'd3, 1'b0);
        nops(3);

        cur_req = "R14 random command stream";
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] rcw;
            int sel;
            if (i % 97 == 0) begin cfg_bl_sel = 2'($urandom_range(0, 3)); cfg_trp = 4'($urandom_range(0, 6)); end
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1:    rcw = C_ACT;
                2:       rcw = C_RD;
                3:       rcw = C_WR;
                4:       rcw = C_PRE;
                5:       rcw = 3'($urandom_range(0, 7));
                default: rcw = C_NOP;
            endcase
            step(($urandom_range(0, 7) == 0), rcw, 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 15) != 0));
        end
        nops(4);

        done = 1;
        summary();
        $finish;
    end
endmodule